// File: doc/BRIEF.md
# Parallel EEPROM Write-Completion Poller

This controller runs single-byte write transactions on a byte-wide parallel EEPROM. It does not wait a fixed worst-case write time. After each write strobe it repeatedly reads the device and watches data bit 6, which the device flips on every read while its internal programming cycle is still running. The write counts as finished when two back-to-back reads return the same bit 6.

If the bit keeps flipping for longer than the worst-case write time (10 ms at the default clock), the controller gives up and raises a timeout flag.

A second command mode checks whether the device's write protection is active. It reads the byte at address 0 and writes back the bitwise complement of that byte. It polls until that write completes, then reads address 0 again. If the byte is unchanged, protection is reported as on. If the byte changed, the controller writes the original value back and polls again, so the stored contents are left intact.

All bus strobes come straight from flops. Every access therefore produces exactly one clean strobe pulse. A split or glitched read would be counted by the device and would spoil the toggle sequence.

Top module: `eeprom_poll_ctrl`

## Requirements
- R1: In write mode (`op_check`=0) the block issues exactly one write strobe, with `mem_addr`=`cmd_addr` and `mem_wdata`=`cmd_data`, followed only by read accesses to the same address until it finishes.
- R2: Polling ends after the first read whose bit 6 equals bit 6 of the read just before it. At least two polling reads are always made, and the block never finishes while successive reads keep disagreeing on bit 6.
- R3: Each bus access keeps `mem_ce_n` low for one cycle before its strobe and drives its strobe (`mem_rd_n` or `mem_wr_n`) low for exactly `STB_CYCLES` consecutive cycles as a single pulse. `mem_addr` is held stable while a strobe is low. `mem_rd_n` and `mem_wr_n` are never low together, and neither is low while `mem_ce_n` is high.
- R4: `busy` rises on the cycle after an accepted `start` and stays high until the command ends. `done` is high for exactly one cycle, the first cycle in which `busy` is low again.
- R5: A `start` pulse while `busy` is high is ignored: no extra access is issued and the address in use does not change.
- R6: If polling has not finished after `TIMEOUT_US` microseconds of `CLK_HZ` cycles, the block ends at the next access boundary with `timed_out`=1, `done` pulsed and `busy` cleared.
- R7: In check mode (`op_check`=1) the block reads address 0, writes the bitwise complement of that byte to address 0 (0xA2 becomes 0x5D), polls to completion, then reads address 0 again.
- R8: If the re-read byte equals the original, `prot_on` is set to 1 and no further write is issued.
- R9: If the re-read byte differs, the original byte is written back to address 0 and polled to completion, leaving `prot_on`=0 and the byte restored.
- R10: After reset, `busy`, `done`, `timed_out` and `prot_on` are 0, `mem_ce_n`, `mem_rd_n` and `mem_wr_n` are 1, and `mem_wdata_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, taken only while idle |
| op_check | input | 1 | 0: write one byte, 1: protection check |
| cmd_addr | input | AW | Target address for a write command |
| cmd_data | input | 8 | Byte to write |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| timed_out | output | 1 | Last command ended by timeout |
| prot_on | output | 1 | Last check found write protection active |
| mem_addr | output | AW | EEPROM address bus |
| mem_wdata | output | 8 | Data driven to the EEPROM |
| mem_wdata_en | output | 1 | Data bus drive enable |
| mem_rdata | input | 8 | Data read from the EEPROM |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |

## Verification
The assertions assume that `mem_rdata` is valid by the last cycle of a read strobe. They also assume `start` is a synchronous pulse. Nothing is assumed about how long the device stays busy.

The bench device model answers combinationally from its array or from its toggle state. It changes state only on strobe rising edges, so read data is always settled when sampled.

Commands are started only at idle, except in the single scenario that deliberately pulses `start` mid-command. The timeout case is reached by a model that never stops toggling, with the bench shortening `TIMEOUT_US` so the run stays short.

// File: rtl/eeprom_poll_ctrl.sv
module eeprom_poll_ctrl #(
  parameter int AW         = 15,
  parameter int CLK_HZ     = 200_000_000,
  parameter int TIMEOUT_US = 10_000,
  parameter int STB_CYCLES = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_check,
  input  logic [AW-1:0] cmd_addr,
  input  logic [7:0]    cmd_data,
  output logic          busy,
  output logic          done,
  output logic          timed_out,
  output logic          prot_on,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          mem_wdata_en,
  input  logic [7:0]    mem_rdata,
  output logic          mem_ce_n,
  output logic          mem_rd_n,
  output logic          mem_wr_n
);
  localparam int TO_CYC = (CLK_HZ / 1_000_000) * TIMEOUT_US;
  localparam int TW     = $clog2(TO_CYC + 1);
  localparam int SW     = $clog2(STB_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_WRITE, S_POLL, S_RD_ORIG, S_RD_CHK} st_t;
  typedef enum logic [1:0] {P_OFF, P_SET, P_STB, P_REC} ph_t;

  st_t          st;
  ph_t          ph;
  logic [SW-1:0] scnt;
  logic [TW-1:0] tcnt;
  logic [7:0]    rbyte, orig;
  logic          prev6, have_prev, restoring, mode_q;

  wire stb_last = (ph == P_STB) && (scnt == SW'(STB_CYCLES - 1));

  assign mem_ce_n     = (ph == P_OFF);
  assign mem_wdata_en = (st == S_WRITE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= P_OFF; scnt <= '0; tcnt <= '0;
      rbyte <= '0; orig <= '0; prev6 <= 1'b0; have_prev <= 1'b0;
      restoring <= 1'b0; mode_q <= 1'b0;
      busy <= 1'b0; done <= 1'b0; timed_out <= 1'b0; prot_on <= 1'b0;
      mem_addr <= '0; mem_wdata <= '0; mem_rd_n <= 1'b1; mem_wr_n <= 1'b1;
    end else begin
      done <= 1'b0;
      if (st == S_POLL && tcnt != TW'(TO_CYC)) tcnt <= tcnt + 1'b1;
      case (ph)
        P_OFF:
          if (start) begin
            busy <= 1'b1; timed_out <= 1'b0; prot_on <= 1'b0;
            restoring <= 1'b0; mode_q <= op_check;
            mem_addr  <= op_check ? '0 : cmd_addr;
            mem_wdata <= cmd_data;
            st <= op_check ? S_RD_ORIG : S_WRITE;
            ph <= P_SET;
          end
        P_SET: begin
          ph <= P_STB; scnt <= '0;
          if (st == S_WRITE) mem_wr_n <= 1'b0;
          else               mem_rd_n <= 1'b0;
        end
        P_STB: begin
          scnt <= scnt + 1'b1;
          if (stb_last) begin
            ph <= P_REC; mem_rd_n <= 1'b1; mem_wr_n <= 1'b1;
            if (st != S_WRITE) rbyte <= mem_rdata;
          end
        end
        P_REC: begin
          ph <= P_SET;
          case (st)
            S_WRITE: begin
              st <= S_POLL; have_prev <= 1'b0; tcnt <= '0;
            end
            S_POLL:
              if (have_prev && rbyte[6] == prev6) begin
                if (!mode_q || restoring) begin
                  st <= S_IDLE; ph <= P_OFF; busy <= 1'b0; done <= 1'b1;
                end else st <= S_RD_CHK;
              end else if (tcnt == TW'(TO_CYC)) begin
                st <= S_IDLE; ph <= P_OFF; busy <= 1'b0; done <= 1'b1;
                timed_out <= 1'b1;
              end else begin
                prev6 <= rbyte[6]; have_prev <= 1'b1;
              end
            S_RD_ORIG: begin
              orig <= rbyte; mem_wdata <= ~rbyte; st <= S_WRITE;
            end
            S_RD_CHK:
              if (rbyte == orig) begin
                prot_on <= 1'b1;
                st <= S_IDLE; ph <= P_OFF; busy <= 1'b0; done <= 1'b1;
              end else begin
                restoring <= 1'b1; mem_wdata <= orig; st <= S_WRITE;
              end
            default: begin
              st <= S_IDLE; ph <= P_OFF;
            end
          endcase
        end
        default: ph <= P_OFF;
      endcase
    end
  end

  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rd_n && !mem_wr_n)); // R3
  AST_STROBE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_n || !mem_wr_n) |-> !mem_ce_n); // R3
  AST_CE_SETUP_RD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rd_n) |-> $past(!mem_ce_n)); // R3
  AST_CE_SETUP_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wr_n) |-> $past(!mem_ce_n)); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_n || !mem_wr_n) |=> $stable(mem_addr)); // R3
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(mem_addr)); // R5
  AST_TIMEOUT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timed_out) |-> (done && !busy)); // R6
  AST_PROT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_on) |-> (done && !busy)); // R8
endmodule

// File: tb/eeprom_poll_ctrl_test.sv
module eeprom_poll_ctrl_test;
  localparam int AW  = 4;
  localparam int STB = 3;
  localparam int TO  = 400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, op_check = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic busy, done, timed_out, prot_on, wd_en, ce_n, rd_n, wr_n;
  logic [AW-1:0] maddr;
  logic [7:0] wdat, rdat;

  always #2.5 clk = ~clk;

  eeprom_poll_ctrl #(.AW(AW), .CLK_HZ(200_000_000), .TIMEOUT_US(2), .STB_CYCLES(STB)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_check(op_check),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy), .done(done),
    .timed_out(timed_out), .prot_on(prot_on), .mem_addr(maddr),
    .mem_wdata(wdat), .mem_wdata_en(wd_en), .mem_rdata(rdat),
    .mem_ce_n(ce_n), .mem_rd_n(rd_n), .mem_wr_n(wr_n));

  // device model
  logic [7:0] mem [16];
  int  busy_reads = 0, busy_len = 0;
  logic tog = 1'b0, protect = 1'b0;
  assign rdat = (busy_reads > 0) ? {1'b0, tog, 6'h15} : mem[maddr];
  always @(posedge rd_n) if (busy_reads > 0) begin tog = ~tog; busy_reads = busy_reads - 1; end
  always @(posedge wr_n) if (!protect) begin mem[maddr] = wdat; busy_reads = busy_len; tog = 1'b0; end

  // bus monitor
  int rd_cnt = 0, wr_cnt = 0, bus_err = 0, run = 0, other_acc = 0;
  logic [7:0] first_wdat;
  logic [AW-1:0] first_waddr;
  logic prev_rd = 1'b1, prev_wr = 1'b1, prev_ce = 1'b1;
  always @(negedge clk) if (rst_n) begin
    if (!rd_n && !wr_n) bus_err++;
    if ((!rd_n || !wr_n) && ce_n) bus_err++;
    if ((!rd_n && prev_rd) || (!wr_n && prev_wr)) begin
      if (prev_ce) bus_err++;
      run = 1;
    end else if (!rd_n || !wr_n) run++;
    if ((rd_n && !prev_rd) || (wr_n && !prev_wr)) if (run != STB) bus_err++;
    if (!rd_n && prev_rd) rd_cnt++;
    if (!wr_n && prev_wr) begin
      if (wr_cnt == 0) begin first_wdat = wdat; first_waddr = maddr; end
      wr_cnt++;
    end
    if ((!rd_n || !wr_n) && maddr != first_waddr && wr_cnt > 0) other_acc++;
    prev_rd = rd_n; prev_wr = wr_n; prev_ce = ce_n;
  end

  int total = 0, bad = 0, cyc = 0, dn = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic run_cmd(input bit chkmode, input logic [AW-1:0] a, input logic [7:0] d, input bit inject);
    rd_cnt = 0; wr_cnt = 0; bus_err = 0; other_acc = 0; cyc = 0; dn = 0;
    @(negedge clk);
    op_check = chkmode; cmd_addr = a; cmd_data = d; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy === 1'b1, "R4 busy after start", busy, 1);
    forever begin
      @(negedge clk);
      cyc++;
      if (inject && cyc == 8) begin cmd_addr = a + 1; cmd_data = ~d; op_check = 1'b1; start = 1'b1; end
      else start = 1'b0;
      if (done) dn++;
      if (!busy || cyc > 5000) break;
    end
    chk(done === 1'b1, "R4 done with busy low", done, 1);
    @(negedge clk);
    if (done) dn++;
    chk(dn == 1, "R4 done width", dn, 1);
  endtask

  task automatic t_reset;
    chk(busy === 0 && done === 0 && timed_out === 0 && prot_on === 0, "R10 flags", {busy, done, timed_out, prot_on}, 0);
    chk(ce_n === 1 && rd_n === 1 && wr_n === 1 && wd_en === 0, "R10 bus idle", {ce_n, rd_n, wr_n, wd_en}, 4'b1110);
  endtask

  task automatic t_write(input logic [AW-1:0] a, input logic [7:0] d, input int lat, input int exp_rd);
    busy_len = lat; protect = 1'b0;
    run_cmd(1'b0, a, d, 1'b0);
    chk(mem[a] == d, "R1 stored byte", mem[a], d);
    chk(wr_cnt == 1 && first_waddr == a, "R1 one write to target", wr_cnt, 1);
    chk(other_acc == 0, "R1 polling same address", other_acc, 0);
    chk(rd_cnt == exp_rd, "R2 poll read count", rd_cnt, exp_rd);
    chk(bus_err == 0, "R3 strobe shape", bus_err, 0);
    chk(timed_out === 0, "R6 no timeout", timed_out, 0);
  endtask

  task automatic t_ignore;
    busy_len = 4; protect = 1'b0; mem[6] = 8'h11;
    run_cmd(1'b0, 4'd5, 8'h3C, 1'b1);
    chk(wr_cnt == 1, "R5 single write", wr_cnt, 1);
    chk(mem[6] == 8'h11, "R5 other address untouched", mem[6], 8'h11);
    chk(mem[5] == 8'h3C, "R5 original command done", mem[5], 8'h3C);
    @(negedge clk);
    chk(busy === 0 && ce_n === 1, "R5 no follow-on command", {busy, ce_n}, 2'b01);
  endtask

  task automatic t_timeout;
    busy_len = 1_000_000; protect = 1'b0;
    run_cmd(1'b0, 4'd2, 8'h77, 1'b0);
    chk(timed_out === 1 && busy === 0, "R6 timeout flag", {timed_out, busy}, 2'b10);
    chk(cyc >= TO && cyc <= TO + 20, "R6 timeout latency", cyc, TO);
    busy_reads = 0;
  endtask

  task automatic t_check(input bit prot);
    mem[0] = 8'hA2; protect = prot; busy_len = 3;
    run_cmd(1'b1, 4'd9, 8'h00, 1'b0);
    chk(first_waddr == 0 && first_wdat == 8'h5D, "R7 complement written to 0", first_wdat, 8'h5D);
    chk(mem[0] == 8'hA2, "R9 byte preserved", mem[0], 8'hA2);
    chk(bus_err == 0, "R3 strobe shape check", bus_err, 0);
    if (prot) begin
      chk(prot_on === 1, "R8 protection on", prot_on, 1);
      chk(wr_cnt == 1, "R8 no restore write", wr_cnt, 1);
    end else begin
      chk(prot_on === 0, "R9 protection off", prot_on, 0);
      chk(wr_cnt == 2, "R9 restore write", wr_cnt, 2);
    end
    protect = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(4'd3, 8'hA5, 5, 6);
    t_write(4'd4, 8'h5A, 5, 7);
    t_write(4'd7, 8'h40, 0, 2);
    t_ignore();
    t_timeout();
    t_check(1'b0);
    t_check(1'b1);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule